// File: doc/BRIEF.md
# Dual Down-Counter Timer with Toggle Output

This block holds two 8-bit down-counters that either run on their own or join into one 16-bit counter. Each counter advances on a count tick. A tick is the `clk_en` strobe, optionally gated by the level of an external event input, which is how pulse widths are measured. When a counter passes zero it reloads from its reload register and produces an underflow pulse.

Underflows set per-timer interrupt flags. The flags are qualified by enable bits and carry a 2-bit priority level. The block presents a single request with the winning level and vector address. A toggle output flips on every underflow of a selectable channel, which halves the underflow rate. It drives one pin directly and a second pin as an inverted copy when the static option is set.

Software reaches all settings through a write port and a combinational read port at 3-bit addresses:
- 0: reload of timer 0
- 1: reload of timer 1
- 2: control
- 3: interrupt configuration
- 4: flags
- 5: live count of timer 0
- 6: live count of timer 1

Each counter is a two-state machine. In HALT the count is held. The transition HALT→RUN happens when the run bit is 1, and it loads the reload value. In RUN the counter decrements on each tick. The transition RUN→HALT happens when the run bit is 0. The toggle output is a two-state machine, LOW⇄HIGH, and it moves only on a pulse from the selected underflow source.

Top module: `duo_timer`

## Requirements
- R1: Setting a run bit (control bit0 for timer 0, bit1 for timer 1) loads the reload value at the next edge. Each later tick decrements the count, which reads back at address 5 or 6. The tick that finds the count at zero is the underflow: it reloads the count, so underflows recur every reload+1 ticks.
- R2: A counter advances only while `clk_en` is 1. With its width-mode bit set (control bit3 for timer 0, bit4 for timer 1), it also advances only while `evt_in` is 1, and otherwise holds its count.
- R3: An underflow sets the timer's flag (flag register bit0 for timer 0, bit1 for timer 1). Writing 1 to a flag bit clears it. A set and a clear in the same cycle leave the flag set.
- R4: `irq_req` is 1 exactly when some flag is 1 and its enable is 1. The enables are interrupt-configuration bit0 for timer 0 and bit1 for timer 1.
- R5: The level fields are at interrupt-configuration bits 3:2 for timer 0 and 5:4 for timer 1. The higher level wins, and timer 1 wins a tie. `irq_level` carries the winner's level. `irq_vector` is 0x000006 for timer 1 and 0x000008 for timer 0.
- R6: With the cascade bit (control bit2) set, run bit0 starts both counters as one 16-bit counter, {count1,count0}. Timer 0 wraps from 0x00 to 0xFF and borrows into timer 1. Both halves reload only when the whole value passes 0x0000. Flag 0 never sets, and flag 1 sets on the 16-bit underflow.
- R7: The toggle output flips once per underflow of the selected channel. The channel is control bit5: 0 selects timer 0 and 1 selects timer 1.
- R8: In cascade mode the toggle follows the 16-bit underflow whatever the value of control bit5.
- R9: Changing control bit5 keeps the toggle level unchanged. Toggling continues only from the newly selected source, with no extra transition.
- R10: `tout_pin` is the toggle level while control bit6 is 1, and 0 otherwise. With the parameter `INV_OPT` set, `tout_n_pin` is its complement under the same enable; it is 0 when the enable is off.
- R11: After reset every readable register reads 0, both counters are halted, the toggle level is low, and `irq_req`, `tout_pin` and `tout_n_pin` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data (combinational) |
| clk_en | input | 1 | Count tick enable |
| evt_in | input | 1 | Event level gating the count in width mode |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 2 | Priority level of the winning request |
| irq_vector | output | 24 | Vector address of the winning request |
| tout_pin | output | 1 | Toggle output pin |
| tout_n_pin | output | 1 | Inverted toggle output pin |

## Verification
Single counters are run with small reload values, so that the spacing of the toggles proves the reload+1 period. The cascade run uses 0x0101. Its 258-tick period and the 0xFF readback separate true 16-bit borrowing from a plain 8-bit reload, and the absence of flag 0 shows that the low half is suppressed. In the width-mode run, `evt_in` and `clk_en` are held low and high in turn, and the count readback shows that ticks land only when both are high. A switch of the channel in mid-run, together with a clear timed onto an underflow edge, shows that the toggle has no glitch and that a set beats a clear.

// File: rtl/duo_timer_pkg.sv
package duo_timer_pkg;

    typedef enum logic [2:0] {
        A_RELOAD0 = 3'd0,
        A_RELOAD1 = 3'd1,
        A_CTRL    = 3'd2,
        A_IRQCFG  = 3'd3,
        A_FLAGS   = 3'd4,
        A_CNT0    = 3'd5,
        A_CNT1    = 3'd6
    } reg_addr_e;

    typedef enum logic {
        CNT_HALT,
        CNT_RUN
    } cnt_state_e;

    typedef enum logic {
        LVL_LOW,
        LVL_HIGH
    } tog_state_e;

    // bit0 run0 ... bit6 pin_en
    typedef struct packed {
        logic pin_en;
        logic chsel;
        logic width1;
        logic width0;
        logic cascade;
        logic run1;
        logic run0;
    } ctrl_t;

endpackage

// File: rtl/dt_counter.sv
module dt_counter
    import duo_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         reload_ok,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         uflow
);

    cnt_state_e state_q, state_d;
    logic       at_zero;

    always_comb begin
        at_zero = (count == '0);
        uflow   = (state_q == CNT_RUN) && run && tick && at_zero;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_HALT: if (run)  state_d = CNT_RUN;
            CNT_RUN:  if (!run) state_d = CNT_HALT;
            default:            state_d = CNT_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_HALT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (state_q == CNT_HALT && run) begin
            count <= reload;
        end else if (state_q == CNT_RUN && run && tick) begin
            if (at_zero && reload_ok) count <= reload;
            else                      count <= count - W'(1);
        end
    end

    assert_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && reload_ok) |=> (count == $past(reload)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_RUN && run && !tick) |=> $stable(count));

endmodule

// File: rtl/dt_irq.sv
module dt_irq #(
    parameter int          LW   = 2,
    parameter int          VW   = 24,
    parameter logic [VW-1:0] VEC0 = 24'h000008,
    parameter logic [VW-1:0] VEC1 = 24'h000006
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set0,
    input  logic          set1,
    input  logic          clr0,
    input  logic          clr1,
    input  logic          en0,
    input  logic          en1,
    input  logic [LW-1:0] lvl0,
    input  logic [LW-1:0] lvl1,
    output logic          flag0,
    output logic          flag1,
    output logic          irq_req,
    output logic [LW-1:0] irq_level,
    output logic [VW-1:0] irq_vector
);

    logic req0, req1, pick1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag0 <= 1'b0;
            flag1 <= 1'b0;
        end else begin
            flag0 <= set0 | (flag0 & ~clr0);
            flag1 <= set1 | (flag1 & ~clr1);
        end
    end

    always_comb begin
        req0    = flag0 & en0;
        req1    = flag1 & en1;
        pick1   = req1 & (!req0 || (lvl1 >= lvl0));
        irq_req = req0 | req1;
        if (pick1) begin
            irq_level  = lvl1;
            irq_vector = VEC1;
        end else if (req0) begin
            irq_level  = lvl0;
            irq_vector = VEC0;
        end else begin
            irq_level  = '0;
            irq_vector = '0;
        end
    end

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set0 || set1) |=> ((flag0 || !$past(set0)) && (flag1 || !$past(set1))));

    assert_vec_t0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_vector == VEC0) |-> (flag0 && en0));

endmodule

// File: rtl/dt_tout.sv
module dt_tout
    import duo_timer_pkg::*;
#(
    parameter bit INV_OPT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src0,
    input  logic src1,
    input  logic sel1,
    input  logic pin_en,
    output logic tout_pin,
    output logic tout_n_pin
);

    tog_state_e state_q, state_d;
    logic       pulse;

    always_comb begin
        pulse   = sel1 ? src1 : src0;
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (pulse) state_d = LVL_HIGH;
            LVL_HIGH: if (pulse) state_d = LVL_LOW;
            default:             state_d = LVL_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        tout_pin = pin_en && (state_q == LVL_HIGH);
        if (INV_OPT) tout_n_pin = pin_en && (state_q == LVL_LOW);
        else         tout_n_pin = 1'b0;
    end

    assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> (state_q != $past(state_q)));

    assert_no_glitch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |=> $stable(state_q));

endmodule

// File: rtl/duo_timer.sv
module duo_timer
    import duo_timer_pkg::*;
#(
    parameter int          CW      = 8,
    parameter int          LW      = 2,
    parameter int          VW      = 24,
    parameter logic [VW-1:0] VEC_T0  = 24'h000008,
    parameter logic [VW-1:0] VEC_T1  = 24'h000006,
    parameter bit          INV_OPT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [2:0]    rd_addr,
    output logic [CW-1:0] rd_data,
    input  logic          clk_en,
    input  logic          evt_in,
    output logic          irq_req,
    output logic [LW-1:0] irq_level,
    output logic [VW-1:0] irq_vector,
    output logic          tout_pin,
    output logic          tout_n_pin
);

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int L0_LSB = 2;
    localparam int L1_LSB = 2 + LW;

    logic [CW-1:0] reload0_q, reload1_q;
    ctrl_t         ctrl_q;
    logic          en0_q, en1_q;
    logic [LW-1:0] lvl0_q, lvl1_q;

    logic [CW-1:0] cnt0, cnt1;
    logic          uflow0, uflow1;
    logic          tick0, tick1, run1_eff, rok0, zero1;
    logic          clr0, clr1, flag0, flag1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload0_q <= '0;
            reload1_q <= '0;
            ctrl_q    <= '0;
            en0_q     <= 1'b0;
            en1_q     <= 1'b0;
            lvl0_q    <= '0;
            lvl1_q    <= '0;
        end else if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                A_RELOAD0: reload0_q <= wr_data;
                A_RELOAD1: reload1_q <= wr_data;
                A_CTRL:    ctrl_q    <= ctrl_t'(wr_data[CTRL_W-1:0]);
                A_IRQCFG: begin
                    en0_q  <= wr_data[0];
                    en1_q  <= wr_data[1];
                    lvl0_q <= wr_data[L0_LSB +: LW];
                    lvl1_q <= wr_data[L1_LSB +: LW];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        clr0 = wr_en && (wr_addr == A_FLAGS) && wr_data[0];
        clr1 = wr_en && (wr_addr == A_FLAGS) && wr_data[1];
    end

    always_comb begin
        rd_data = '0;
        unique case (reg_addr_e'(rd_addr))
            A_RELOAD0: rd_data = reload0_q;
            A_RELOAD1: rd_data = reload1_q;
            A_CTRL:    rd_data[CTRL_W-1:0] = ctrl_q;
            A_IRQCFG: begin
                rd_data[0] = en0_q;
                rd_data[1] = en1_q;
                rd_data[L0_LSB +: LW] = lvl0_q;
                rd_data[L1_LSB +: LW] = lvl1_q;
            end
            A_FLAGS: begin
                rd_data[0] = flag0;
                rd_data[1] = flag1;
            end
            A_CNT0:  rd_data = cnt0;
            A_CNT1:  rd_data = cnt1;
            default: rd_data = '0;
        endcase
    end

    always_comb begin
        tick0    = clk_en && (!ctrl_q.width0 || evt_in);
        tick1    = ctrl_q.cascade ? uflow0
                                  : (clk_en && (!ctrl_q.width1 || evt_in));
        run1_eff = ctrl_q.cascade ? ctrl_q.run0 : ctrl_q.run1;
        zero1    = (cnt1 == '0);
        rok0     = !ctrl_q.cascade || zero1;
    end

    dt_counter #(.W(CW)) u_cnt0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl_q.run0),
        .tick      (tick0),
        .reload_ok (rok0),
        .reload    (reload0_q),
        .count     (cnt0),
        .uflow     (uflow0)
    );

    dt_counter #(.W(CW)) u_cnt1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run1_eff),
        .tick      (tick1),
        .reload_ok (1'b1),
        .reload    (reload1_q),
        .count     (cnt1),
        .uflow     (uflow1)
    );

    dt_irq #(.LW(LW), .VW(VW), .VEC0(VEC_T0), .VEC1(VEC_T1)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set0       (uflow0 && !ctrl_q.cascade),
        .set1       (uflow1),
        .clr0       (clr0),
        .clr1       (clr1),
        .en0        (en0_q),
        .en1        (en1_q),
        .lvl0       (lvl0_q),
        .lvl1       (lvl1_q),
        .flag0      (flag0),
        .flag1      (flag1),
        .irq_req    (irq_req),
        .irq_level  (irq_level),
        .irq_vector (irq_vector)
    );

    dt_tout #(.INV_OPT(INV_OPT)) u_tout (
        .clk        (clk),
        .rst_n      (rst_n),
        .src0       (uflow0),
        .src1       (uflow1),
        .sel1       (ctrl_q.cascade || ctrl_q.chsel),
        .pin_en     (ctrl_q.pin_en),
        .tout_pin   (tout_pin),
        .tout_n_pin (tout_n_pin)
    );

    assert_casc_no_flag0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.cascade && !flag0) |=> !flag0);

    assert_casc_borrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.cascade && uflow0 && !zero1) |=> (cnt0 == {CW{1'b1}}));

endmodule

// File: tb/tb_duo_timer.sv
module tb_duo_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        clk_en = 1'b1;
    logic        evt_in = 1'b0;
    logic        irq_req;
    logic [1:0]  irq_level;
    logic [23:0] irq_vector;
    logic        tout_pin, tout_n_pin;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int q[$];
    bit mon_on = 1'b0;
    logic prev_pin = 1'b0;

    duo_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .clk_en(clk_en), .evt_in(evt_in), .irq_req(irq_req),
        .irq_level(irq_level), .irq_vector(irq_vector),
        .tout_pin(tout_pin), .tout_n_pin(tout_n_pin)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // caller is at a negedge; returns the cycle of the write edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d, output int at);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1 at = cyc;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input int exp, input string tag);
        rd_addr = a; #1;
        chk(tag, int'(rd_data), exp);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // scoreboard monitor: each toggle of the pin is matched to the queue
    always @(negedge clk) begin
        if (mon_on) begin
            if (tout_pin !== prev_pin) begin
                n_chk++;
                if (q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R7/R9: unexpected toggle at cycle %0d, actual %0d expected none",
                             cyc, tout_pin);
                end else begin
                    int e;
                    e = q.pop_front();
                    if (e != cyc) begin
                        n_fail++;
                        $display("FAIL R7: toggle at cycle %0d expected %0d", cyc, e);
                    end
                end
                n_chk++;
                if (tout_n_pin !== ~tout_pin) begin
                    n_fail++;
                    $display("FAIL R10: inverted pin actual %0d expected %0d",
                             tout_n_pin, ~tout_pin);
                end
            end
            prev_pin = tout_pin;
        end
    end

    task automatic drain(input string tag);
        chk(tag, q.size(), 0);
        q.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int w, d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        for (int a = 0; a < 7; a++) rd(3'(a), 0, "R11 register reset");
        chk("R11 irq_req", irq_req, 0);
        chk("R11 tout_pin", tout_pin, 0);
        chk("R11 tout_n_pin", tout_n_pin, 0);
        mon_on = 1'b1;

        // en0=1 en1=1 lvl0=2 lvl1=1
        wr(3'd3, 8'h1B, d);

        // R1 timer 0 alone, reload 3
        wr(3'd0, 8'd3, d);
        wr(3'd2, 8'h41, w);
        q.push_back(w + 5); q.push_back(w + 9); q.push_back(w + 13);
        wait_until(w + 2);
        rd(3'd5, 2, "R1 count after first tick");
        wait_until(w + 6);
        rd(3'd4, 1, "R3 flag0 set by underflow");
        wr(3'd4, 8'h01, d);
        rd(3'd4, 0, "R3 write-1 clear");
        wait_until(w + 12);
        wr(3'd4, 8'h01, d);
        rd(3'd4, 1, "R3 set wins over clear");
        wait_until(w + 15);
        wr(3'd2, 8'h40, d);
        drain("R1 toggles every reload+1");
        chk("R4 irq_req", irq_req, 1);
        chk("R5 level t0", irq_level, 2);
        chk("R5 vector t0", int'(irq_vector), 8);
        wr(3'd4, 8'h01, d);
        chk("R4 irq_req after clear", irq_req, 0);

        // R7 timer 1 selected, reload 2
        wr(3'd1, 8'd2, d);
        wr(3'd2, 8'h62, w);
        q.push_back(w + 4); q.push_back(w + 7); q.push_back(w + 10);
        wait_until(w + 11);
        wr(3'd2, 8'h60, d);
        drain("R7 channel 1 toggles");
        rd(3'd4, 2, "R3 only flag1 set");
        chk("R5 level t1", irq_level, 1);
        chk("R5 vector t1", int'(irq_vector), 6);

        // R5 arbitration: run timer 0 with channel 1 selected (no toggles)
        wr(3'd2, 8'h61, w);
        wait_until(w + 6);
        wr(3'd2, 8'h60, d);
        rd(3'd4, 3, "R3 both flags");
        chk("R5 higher level t0 wins vector", int'(irq_vector), 8);
        chk("R5 higher level t0 wins level", irq_level, 2);
        wr(3'd3, 8'h17, d);
        chk("R5 tie goes to t1", int'(irq_vector), 6);
        wr(3'd3, 8'h15, d);
        chk("R4 en1 off masks t1", int'(irq_vector), 8);
        chk("R4 en1 off level", irq_level, 1);
        wr(3'd3, 8'h14, d);
        chk("R4 no enables no request", irq_req, 0);
        wr(3'd4, 8'h03, d);
        wr(3'd3, 8'h1B, d);

        // R6/R8 cascade, reload 0x0101, channel bit 0 ignored
        wr(3'd0, 8'd1, d);
        wr(3'd1, 8'd1, d);
        wr(3'd2, 8'h45, w);
        q.push_back(w + 259); q.push_back(w + 517);
        wait_until(w + 3);
        rd(3'd5, 255, "R6 low half borrows to FF");
        rd(3'd6, 0, "R6 high half decremented");
        wait_until(w + 518);
        wr(3'd2, 8'h40, d);
        drain("R8 toggles follow 16-bit underflow");
        rd(3'd4, 2, "R6 flag0 suppressed, flag1 set");
        wr(3'd4, 8'h03, d);

        // R2 width mode on timer 0, reload 3
        wr(3'd0, 8'd3, d);
        wr(3'd2, 8'h49, w);
        wait_until(w + 10);
        rd(3'd5, 3, "R2 held while evt_in low");
        evt_in = 1'b1;
        wait_until(w + 12);
        rd(3'd5, 1, "R2 counts while evt_in high");
        clk_en = 1'b0;
        wait_until(w + 16);
        rd(3'd5, 1, "R2 held while clk_en low");
        q.push_back(w + 18);
        clk_en = 1'b1;
        wait_until(w + 19);
        wr(3'd2, 8'h48, d);
        evt_in = 1'b0;
        drain("R2 underflow after gated ticks");
        wr(3'd4, 8'h03, d);

        // R9 channel switch mid-run: t0 reload 3, t1 reload 5
        wr(3'd1, 8'd5, d);
        wr(3'd2, 8'h43, w);
        q.push_back(w + 5); q.push_back(w + 9); q.push_back(w + 13); q.push_back(w + 19);
        wait_until(w + 9);
        wr(3'd2, 8'h63, d);
        wait_until(w + 20);
        wr(3'd2, 8'h60, d);
        drain("R9 switch keeps level");

        // R10 pins: 13 toggles so far, level high
        mon_on = 1'b0;
        chk("R10 tout_pin high", tout_pin, 1);
        chk("R10 tout_n_pin low", tout_n_pin, 0);
        wr(3'd2, 8'h00, d);
        chk("R10 tout_pin disabled", tout_pin, 0);
        chk("R10 tout_n_pin disabled", tout_n_pin, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule